// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Sequencer

This block fronts a small working SRAM that has a nonvolatile shadow copy of the same size. Host accesses arrive as active-low chip-enable, output-enable and write-enable levels, sampled on the block clock. The block turns them into single-word reads and writes of the working array. It also copies the whole array into the shadow (a store) or back out of it (a recall), one word per clock.

A store can be started three ways. The first is a shared active-low request/busy line, which other parties pull low. The second is a one-cycle software command strobe. The third is a falling power-good input. A recall is queued whenever power is absent, including right after reset, and it runs on its own once power-good returns.

A dirty flag tracks writes since the last transfer. Line-requested and power-fail stores are skipped when nothing has changed. The busy line is shared in wired-AND fashion: the block only drives a pull-low enable, and it reads back the resolved level of the line.

Top module: `nvsram_seq`

## Requirements
- R1: A read is accepted on a clock where `ce_n`=0, `oe_n`=0 and `we_n`=1, while the block is idle with `busy_in`=1 or is inside the settle window. `rdata` then holds the addressed word and `rdata_vld`=1 one cycle later. Otherwise `rdata_vld`=0.
- R2: A write is accepted on a clock where `ce_n`=0 and `we_n`=0, while the block is idle with `busy_in`=1. The word is stored at `addr`. With `ce_n`=1 the array is left unchanged. When `oe_n`=0 and `we_n`=0 together, the write is taken and no read is reported.
- R3: No read or write is accepted while a store or recall is running, or while power-good is low.
- R4: A store started by the request line or by loss of power runs only if the dirty flag is set. A store started by `sw_store` (taken only when idle with `busy_in`=1) always runs.
- R5: After `busy_in` is first seen low while idle, a store (when due) begins driving busy `DELAY_CYC`+1 cycles later. During that window, reads are still served, and a write that was already accepted on the previous clock continues to be taken.
- R6: A write started after the request line has fallen is refused until the line is high again.
- R7: `busy_drv` is 1 for exactly 2^`AW` cycles for every store, whatever started it, and is 0 at all other times.
- R8: After a line-requested store, or a skipped one, no access is accepted until `busy_in` has returned high.
- R9: When power-good rises, a recall starts on the next clock, lasts `RECALL_CYC` cycles, and restores the shadow contents into the working array. `recall_done` is seen `RECALL_CYC`+1 cycles after the rise.
- R10: Every accepted write sets the dirty flag. The end of every store and every recall clears it.
- R11: `store_done` and `recall_done` are single-cycle pulses, raised in the cycle after a transfer's final word. Both are 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_ok | input | 1 | Supply above threshold |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| rdata_vld | output | 1 | Read accepted on the previous clock |
| busy_in | input | 1 | Resolved level of the shared request/busy line |
| busy_drv | output | 1 | Pull-low enable for the shared line (store running) |
| sw_store | input | 1 | One-cycle software store command |
| store_done | output | 1 | Store finished pulse |
| recall_done | output | 1 | Recall finished pulse |

## Verification
The hardest situation to reach is the boundary of the settle window. A write has to be in flight just as the request line falls, and then a new write and a read have to land inside the window before the store takes the line. The bench gets there by holding write-enable low across the clock on which it pulls the line low and changing the data on that same edge. It then releases the write, waits a cycle, and starts a new write and a read, all counted from that edge against a short `DELAY_CYC`. Recovery of stored data is observed only through a full power-down and recall, so each store is checked by reading back after power-good is cycled.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_PWRDN  = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_STORE  = 3'd4,
    ST_LOCK   = 3'd5
  } nvs_state_e;

  typedef enum logic [1:0] {
    SRC_SW = 2'd0,
    SRC_HW = 2'd1,
    SRC_PF = 2'd2
  } nvs_src_e;

endpackage

// File: rtl/nvs_access.sv
module nvs_access (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic busy_in,
  input  logic acc_open,
  input  logic acc_settle,
  output logic rd_ok,
  output logic wr_ok
);

  logic wr_prev_q;
  logic cyc_wr;
  logic cyc_rd;

  assign cyc_wr = !ce_n && !we_n;
  assign cyc_rd = !ce_n && !oe_n && we_n;

  always_comb begin
    wr_ok = cyc_wr && ((acc_open && busy_in) ||
                       ((acc_open || acc_settle) && wr_prev_q));
    rd_ok = cyc_rd && ((acc_open && busy_in) || acc_settle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_ok;
  end

  AST_SETTLE_NO_NEW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_settle && !$past(wr_ok)) |-> !wr_ok); // R6

  AST_WRITE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !busy_in) |-> $past(wr_ok)); // R2

endmodule

// File: rtl/nvs_mem.sv
module nvs_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld,
  input  logic          st_we,
  input  logic          rc_we,
  input  logic [AW-1:0] xfer_idx
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] sram_rd;

  // One working word and its shadow per address; transfers and host writes
  // never share a clock, so each word sees a single writer per cycle.
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DW-1:0] work_q;
    logic [DW-1:0] shadow_q;
    logic          host_hit;
    logic          xfer_hit;

    assign host_hit   = wr_en && (addr == AW'(w));
    assign xfer_hit   = (xfer_idx == AW'(w));
    assign sram_rd[w] = work_q;

    always_ff @(posedge clk) begin
      if (rc_we && xfer_hit)  work_q <= shadow_q;
      else if (host_hit)      work_q <= wdata;
    end

    always_ff @(posedge clk) begin
      if (st_we && xfer_hit) shadow_q <= work_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= rd_en;
      if (rd_en) rdata <= sram_rd[addr];
    end
  end

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DELAY_CYC  = 6,
  parameter int RECALL_CYC = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          busy_in,
  input  logic          sw_store,
  input  logic          wr_ok,
  input  logic          rd_ok,
  output logic          acc_open,
  output logic          acc_settle,
  output logic          st_we,
  output logic          rc_we,
  output logic [AW-1:0] xfer_idx,
  output logic          busy_drv,
  output logic          store_done,
  output logic          recall_done
);

  localparam int DEPTH = 1 << AW;
  localparam int MAX_A = (DEPTH > DELAY_CYC) ? DEPTH : DELAY_CYC;
  localparam int MAXC  = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  nvs_state_e    state_q, state_d;
  nvs_src_e      src_q, src_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dirty_q, dirty_d;
  logic          sdone_d, rdone_d;
  logic          dirty_now;
  logic          last_st, last_rc, last_set;

  assign last_st   = (cnt_q == CW'(DEPTH - 1));
  assign last_rc   = (cnt_q == CW'(RECALL_CYC - 1));
  assign last_set  = (cnt_q == CW'(DELAY_CYC - 1));
  assign dirty_now = dirty_q || wr_ok;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dirty_d = dirty_now;
    case (state_q)
      ST_PWRDN: begin
        if (pwr_ok) state_d = ST_RECALL;
      end
      ST_RECALL: begin
        if (last_rc) begin
          dirty_d = 1'b0;
          state_d = pwr_ok ? ST_IDLE : ST_PWRDN;
        end
      end
      ST_IDLE: begin
        if (!pwr_ok) begin
          src_d   = SRC_PF;
          state_d = dirty_now ? ST_STORE : ST_PWRDN;
        end else if (!busy_in) begin
          src_d   = SRC_HW;
          state_d = ST_SETTLE;
        end else if (sw_store) begin
          src_d   = SRC_SW;
          state_d = ST_STORE;
        end
      end
      ST_SETTLE: begin
        if (last_set) state_d = dirty_now ? ST_STORE : ST_LOCK;
      end
      ST_STORE: begin
        if (last_st) begin
          dirty_d = 1'b0;
          if (src_q == SRC_PF || !pwr_ok) state_d = ST_PWRDN;
          else if (src_q == SRC_HW)       state_d = ST_LOCK;
          else                            state_d = ST_IDLE;
        end
      end
      ST_LOCK: begin
        if (!pwr_ok)      state_d = ST_PWRDN;
        else if (busy_in) state_d = ST_IDLE;
      end
      default: state_d = ST_PWRDN;
    endcase
    cnt_d   = (state_d != state_q) ? '0 : cnt_q + CW'(1);
    sdone_d = (state_q == ST_STORE) && last_st;
    rdone_d = (state_q == ST_RECALL) && last_rc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PWRDN;
      src_q       <= SRC_SW;
      cnt_q       <= '0;
      dirty_q     <= 1'b0;
      store_done  <= 1'b0;
      recall_done <= 1'b0;
    end else begin
      state_q     <= state_d;
      src_q       <= src_d;
      cnt_q       <= cnt_d;
      dirty_q     <= dirty_d;
      store_done  <= sdone_d;
      recall_done <= rdone_d;
    end
  end

  assign acc_open   = (state_q == ST_IDLE);
  assign acc_settle = (state_q == ST_SETTLE);
  assign st_we      = (state_q == ST_STORE);
  assign rc_we      = (state_q == ST_RECALL) && (cnt_q < CW'(DEPTH));
  assign xfer_idx   = cnt_q[AW-1:0];
  assign busy_drv   = (state_q == ST_STORE);

  AST_NO_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_STORE, ST_RECALL, ST_PWRDN, ST_LOCK}) |-> !wr_ok); // R3

  AST_NO_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_STORE, ST_RECALL, ST_PWRDN, ST_LOCK}) |-> !rd_ok); // R3

  AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_drv) && src_q != SRC_SW) |-> dirty_q); // R4

  AST_DIRTY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done || recall_done) |-> !dirty_q); // R10

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !busy_in && pwr_ok) |=> (state_q == ST_LOCK)); // R8

endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq #(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int DELAY_CYC  = 6,
  parameter int RECALL_CYC = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld,
  input  logic          busy_in,
  output logic          busy_drv,
  input  logic          sw_store,
  output logic          store_done,
  output logic          recall_done
);

  logic          rst_meta, rst_sn;
  logic          acc_open, acc_settle;
  logic          rd_ok, wr_ok;
  logic          st_we, rc_we;
  logic [AW-1:0] xfer_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  nvs_access u_access (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .busy_in   (busy_in),
    .acc_open  (acc_open),
    .acc_settle(acc_settle),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok)
  );

  nvs_ctrl #(
    .AW        (AW),
    .DELAY_CYC (DELAY_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .pwr_ok     (pwr_ok),
    .busy_in    (busy_in),
    .sw_store   (sw_store),
    .wr_ok      (wr_ok),
    .rd_ok      (rd_ok),
    .acc_open   (acc_open),
    .acc_settle (acc_settle),
    .st_we      (st_we),
    .rc_we      (rc_we),
    .xfer_idx   (xfer_idx),
    .busy_drv   (busy_drv),
    .store_done (store_done),
    .recall_done(recall_done)
  );

  nvs_mem #(
    .AW(AW),
    .DW(DW)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_ok),
    .addr     (addr),
    .wdata    (wdata),
    .rd_en    (rd_ok),
    .rdata    (rdata),
    .rdata_vld(rdata_vld),
    .st_we    (st_we),
    .rc_we    (rc_we),
    .xfer_idx (xfer_idx)
  );

  AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_sn)
    rdata_vld |-> $past(!ce_n && !oe_n && we_n)); // R1

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    store_done |-> ($past(busy_drv) && !busy_drv)); // R7

  AST_STORE_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    store_done |=> !store_done); // R11

  AST_RECALL_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    recall_done |=> !recall_done); // R11

endmodule

// File: tb/nvsram_seq_tb.sv
`timescale 1ns/1ps
module nvsram_seq_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DLY = 6;
  localparam int RCY = 24;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, ce_n, oe_n, we_n, sw_store, ext_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rdata_vld, busy_drv, busy_in, store_done, recall_done;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Wired-AND of the external requester and the block's own pull-down.
  assign busy_in = ext_n & ~busy_drv;

  nvsram_seq #(.AW(AW), .DW(DW), .DELAY_CYC(DLY), .RECALL_CYC(RCY)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_vld(rdata_vld), .busy_in(busy_in), .busy_drv(busy_drv),
    .sw_store(sw_store), .store_done(store_done), .recall_done(recall_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output logic v);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk); d = rdata; v = rdata_vld; ce_n = 1; oe_n = 1;
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input logic [DW-1:0] e,
                             input string req);
    logic [DW-1:0] d; logic v;
    do_read(a, d, v);
    chk(v === 1'b1 && d === e, req, "read data", int'(d), int'(e));
  endtask

  task automatic expect_no_read(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] d; logic v;
    do_read(a, d, v);
    chk(v === 1'b0, req, "read refused", int'(v), 0);
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_store = 1;
    @(negedge clk); sw_store = 0;
  endtask

  // Returns number of sampled cycles with busy driven; leaves at store_done.
  task automatic wait_store_end(output int n);
    n = 0;
    while (busy_drv && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_recall(output int n);
    n = 0;
    while (!recall_done && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    int n;
    rst_n = 0; pwr_ok = 1; ce_n = 1; oe_n = 1; we_n = 1; sw_store = 0;
    ext_n = 1; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(busy_drv === 1'b0, "R7", "busy in reset", int'(busy_drv), 0);
    chk(store_done === 1'b0 && recall_done === 1'b0, "R11", "done in reset",
        int'({store_done, recall_done}), 0);
    chk(rdata_vld === 1'b0, "R1", "vld in reset", int'(rdata_vld), 0);
    rst_n = 1;
    wait_recall(n);
    chk(recall_done === 1'b1, "R9", "power-up recall", int'(recall_done), 1);
    @(negedge clk);
    chk(recall_done === 1'b0, "R11", "recall pulse width", int'(recall_done), 0);
  endtask

  task automatic t_rw_basic();
    logic [DW-1:0] d; logic v;
    do_write(2, 8'hC2); do_write(5, 8'h55); do_write(15, 8'hF0);
    expect_read(2, 8'hC2, "R2");
    expect_read(15, 8'hF0, "R2");
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = 5;
    @(negedge clk); v = rdata_vld; ce_n = 1;
    chk(v === 1'b0, "R1", "oe high no read", int'(v), 0);
    @(negedge clk); ce_n = 1; we_n = 0; addr = 5; wdata = 8'h99;
    @(negedge clk); we_n = 1;
    expect_read(5, 8'h55, "R2");
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 5; wdata = 8'h5F;
    @(negedge clk); v = rdata_vld; ce_n = 1; oe_n = 1; we_n = 1;
    chk(v === 1'b0, "R2", "write wins no read", int'(v), 0);
    do_read(5, d, v);
    chk(v === 1'b1 && d === 8'h5F, "R2", "write with oe low", int'(d), 'h5F);
  endtask

  task automatic t_sw_store();
    int n;
    do_write(1, 8'hA1);
    pulse_sw();
    wait_store_end(n);
    chk(n == DEPTH, "R7", "busy length sw", n, DEPTH);
    chk(store_done === 1'b1, "R11", "store_done at end", int'(store_done), 1);
    @(negedge clk);
    chk(store_done === 1'b0, "R11", "store_done width", int'(store_done), 0);
    pulse_sw();
    chk(busy_drv === 1'b1, "R4", "clean sw store runs", int'(busy_drv), 1);
    do_write(1, 8'hB2);
    expect_no_read(1, "R3");
    wait_store_end(n);
    repeat (2) @(negedge clk);
    expect_read(1, 8'hA1, "R3");
  endtask

  task automatic t_hw_skip(input string req);
    bit seen = 0;
    @(negedge clk); ext_n = 0;
    for (int i = 0; i < DLY + DEPTH + 4; i++) begin
      @(negedge clk);
      if (busy_drv || store_done) seen = 1;
    end
    chk(!seen, req, "clean line store skipped", int'(seen), 0);
    ext_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_hw_store();
    int c0, n;
    logic [DW-1:0] d; logic v;
    do_write(3, 8'h11); do_write(9, 8'h22);
    @(negedge clk); ce_n = 0; we_n = 0; addr = 3; wdata = 8'h33;
    @(negedge clk); ext_n = 0; wdata = 8'h44; c0 = cyc;
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk); ce_n = 0; we_n = 0; addr = 9; wdata = 8'h99;
    @(negedge clk); ce_n = 1; we_n = 1;
    do_read(3, d, v);
    chk(v === 1'b1 && d === 8'h44, "R5", "read in settle / carried write",
        int'(d), 'h44);
    n = 0;
    while (!busy_drv && n < 100) begin @(negedge clk); n++; end
    chk(cyc - c0 == DLY + 1, "R5", "settle length", cyc - c0, DLY + 1);
    wait_store_end(n);
    chk(n == DEPTH, "R7", "busy length hw", n, DEPTH);
    expect_no_read(3, "R8");
    do_write(9, 8'h77);
    @(negedge clk); ext_n = 1;
    @(negedge clk);
    expect_read(9, 8'h22, "R6");
    expect_read(3, 8'h44, "R8");
  endtask

  task automatic t_pf_clean();
    int c0, n;
    bit seen = 0;
    @(negedge clk); pwr_ok = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy_drv) seen = 1;
    end
    chk(!seen, "R4", "clean power-fail skipped", int'(seen), 0);
    expect_no_read(3, "R3");
    @(negedge clk); pwr_ok = 1; c0 = cyc;
    wait_recall(n);
    chk(cyc - c0 == RCY + 1, "R9", "recall length", cyc - c0, RCY + 1);
    expect_read(3, 8'h44, "R9");
    expect_read(9, 8'h22, "R9");
  endtask

  task automatic t_pf_dirty();
    int n;
    do_write(7, 8'h5A);
    @(negedge clk); pwr_ok = 0;
    @(negedge clk);
    chk(busy_drv === 1'b1, "R4", "dirty power-fail store", int'(busy_drv), 1);
    wait_store_end(n);
    chk(n == DEPTH, "R7", "busy length pf", n, DEPTH);
    @(negedge clk); pwr_ok = 1;
    @(negedge clk);
    expect_no_read(7, "R3");
    wait_recall(n);
    @(negedge clk);
    expect_read(7, 8'h5A, "R9");
    t_hw_skip("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rw_basic();
    t_sw_store();
    t_hw_skip("R4");
    t_hw_store();
    t_pf_clean();
    t_pf_dirty();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule